// File: doc/BRIEF.md
# Sample-and-Convert Sequencer

This block times one sample-and-convert cycle for a sampled video signal. It watches a source-start strobe. On the clock edge that first sees it rise, it starts a microsecond time base. It then raises a track/hold control and, a few microseconds later while hold is still high, an ADC start pulse. Each of these outputs stays high for a fixed window.

Once the start pulse is up, the sequencer waits for the successive-approximation controller to pull its active-low completion flag. A fixed time after that, the sequencer drives its own active-low done flag. If the completion flag never arrives within a timeout window, the sequencer drops both pulses, raises a one-cycle error pulse and goes back to idle.

Every delay is a parameter in microseconds. The number of system clocks per microsecond is also a parameter. All pins are plain control and status levels; there is no data stream and no handshake.

Top module: `samp_conv_seq`

## Requirements
- R1: While reset is held and right after it, hold_o and conv_start_o are 0, done_n_o is 1 and tmo_err_o is 0.
- R2: The accepting edge E0 is the clock edge at which src_start_i is sampled 1 after being sampled 0 while idle. hold_o goes to 1 exactly HOLD_DLY_US*CLK_PER_US clocks after E0.
- R3: conv_start_o goes to 1 exactly CONV_DLY_US*CLK_PER_US clocks after E0, and hold_o is already 1 at that moment.
- R4: hold_o returns to 0 exactly (HOLD_DLY_US+HOLD_LEN_US)*CLK_PER_US clocks after E0.
- R5: Without a timeout, conv_start_o returns to 0 exactly (CONV_DLY_US+CONV_LEN_US)*CLK_PER_US clocks after E0.
- R6: cmplt_n_i may be sampled 0 after conv_start_o has risen. If so, done_n_o goes to 0 exactly DONE_DLY_US*CLK_PER_US clocks after that sampling edge, and it stays 0.
- R7: cmplt_n_i sampled 0 before conv_start_o rises is ignored. done_n_o then follows only the later, genuine completion.
- R8: A source-start rising edge that arrives while a sequence runs is ignored. The pulse timing is unchanged and done_n_o is not released.
- R9: done_n_o is released to 1 at the accepting edge of the next sequence.
- R10: The sequencer may reach CMPLT_TMO_US*CLK_PER_US clocks after conv_start_o rose without sampling cmplt_n_i as 0. In that case, at that edge, conv_start_o and hold_o go to 0, tmo_err_o is 1 for exactly one clock, done_n_o stays 1 and the sequencer is idle.
- R11: The sequencer is idle again once done has been asserted and both pulse windows have ended. A start edge right after that is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_start_i | input | 1 | Source-start strobe; the rising edge starts a sequence |
| cmplt_n_i | input | 1 | Active-low conversion-complete flag from the converter controller |
| hold_o | output | 1 | Track/hold control, high means hold |
| conv_start_o | output | 1 | Start pulse to the converter controller |
| done_n_o | output | 1 | Active-low sequence-done flag |
| tmo_err_o | output | 1 | One-cycle pulse when the completion flag timed out |

## Verification
The hardest case is the race between the completion flag and the timeout. On the last edge of the window, completion must win. One clock later it must be ignored, because the sequencer has already aborted. The stimulus measures the completion delay in clocks from the observed rise of conv_start_o. Directed runs place that delay exactly on the last legal cycle and on the first cycle beyond it. Random runs cover the range on both sides. Early completion glitches and start edges during a running sequence are mixed in at random offsets.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,  // waiting for a source-start edge
    ST_LEAD = 3'd1,  // counting towards the convert-start edge
    ST_WAIT = 3'd2,  // convert-start is up, waiting for completion
    ST_DLY  = 3'd3,  // completion seen, counting the done delay
    ST_TAIL = 3'd4   // done asserted, letting the pulse windows finish
  } seq_state_e;

  function automatic int umax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cseq_tick.sv
// Restartable microsecond prescaler: tick_o is high on the last clock
// of every CLK_PER_US-clock interval counted from the last restart.
module cseq_tick #(
  parameter int CLK_PER_US = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);

  logic [CW-1:0] pre_q;

  assign tick_o = (pre_q == LAST) && !restart_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (restart_i || pre_q == LAST) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((CLK_PER_US > 1) && tick_o) |=> !tick_o);

endmodule

// File: rtl/cseq_ucount.sv
// Saturating microsecond counter; next_o is the value the counter takes
// at the coming edge, so registered decodes of it carry no extra lag.
module cseq_ucount #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         tick_i,
  output logic [W-1:0] next_o
);
  localparam logic [W-1:0] CMAX = '1;

  logic [W-1:0] count_q;

  always_comb begin
    if (clear_i) begin
      next_o = '0;
    end else if (tick_i && count_q != CMAX) begin
      next_o = count_q + 1'b1;
    end else begin
      next_o = count_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else begin
      count_q <= next_o;
    end
  end

  // R8
  count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> count_q >= $past(count_q));

endmodule

// File: rtl/samp_conv_seq.sv
module samp_conv_seq
  import cseq_pkg::*;
#(
  parameter int CLK_PER_US   = 50,
  parameter int HOLD_DLY_US  = 15,
  parameter int HOLD_LEN_US  = 18,
  parameter int CONV_DLY_US  = 19,
  parameter int CONV_LEN_US  = 31,
  parameter int DONE_DLY_US  = 2,
  parameter int CMPLT_TMO_US = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_start_i,
  input  logic cmplt_n_i,
  output logic hold_o,
  output logic conv_start_o,
  output logic done_n_o,
  output logic tmo_err_o
);
  // Derived time points, all in microseconds from the accepting edge.
  localparam int HOLD_END = HOLD_DLY_US + HOLD_LEN_US;
  localparam int CONV_END = CONV_DLY_US + CONV_LEN_US;
  localparam int SEQ_END  = umax(HOLD_END, CONV_END);
  localparam int TMO_AT   = CONV_DLY_US + CMPLT_TMO_US;
  localparam int SPAN     = SEQ_END + TMO_AT + DONE_DLY_US + 2;
  localparam int UW       = $clog2(SPAN + 1);
  localparam bit OVERLAP  = (CONV_DLY_US >= HOLD_DLY_US) && (CONV_DLY_US < HOLD_END);

  localparam logic [UW-1:0] HOLD_ON_C  = UW'(HOLD_DLY_US);
  localparam logic [UW-1:0] HOLD_OFF_C = UW'(HOLD_END);
  localparam logic [UW-1:0] CONV_ON_C  = UW'(CONV_DLY_US);
  localparam logic [UW-1:0] CONV_OFF_C = UW'(CONV_END);
  localparam logic [UW-1:0] END_C      = UW'(SEQ_END);
  localparam logic [UW-1:0] TMO_C      = UW'(TMO_AT);
  localparam logic [UW-1:0] DONE_C     = UW'(DONE_DLY_US);

  // Time base 0 runs from the accepting edge, time base 1 from completion.
  localparam int NTB    = 2;
  localparam int TB_SEQ = 0;
  localparam int TB_DON = 1;

  seq_state_e state_q, state_d;
  logic       src_q;
  logic       hold_q, conv_q, done_n_q, err_q;
  logic       hold_d, conv_d, done_n_d, err_d;

  logic       start_edge, accept, cmplt_hit, abort, done_due;
  logic [NTB-1:0] tb_restart, tb_tick;
  logic [UW-1:0]  tb_next [NTB];
  logic [UW-1:0]  seq_us, don_us;

  // ---------------------------------------------------------------
  // Start-edge detection and acceptance
  // ---------------------------------------------------------------
  assign start_edge = src_start_i && !src_q;
  assign accept     = (state_q == ST_IDLE) && start_edge;
  assign cmplt_hit  = (state_q == ST_WAIT) && !cmplt_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= 1'b0;
    end else begin
      src_q <= src_start_i;
    end
  end

  // ---------------------------------------------------------------
  // Restartable time bases
  // ---------------------------------------------------------------
  assign tb_restart[TB_SEQ] = accept;
  assign tb_restart[TB_DON] = cmplt_hit;

  for (genvar g = 0; g < NTB; g++) begin : g_tb
    cseq_tick #(
      .CLK_PER_US(CLK_PER_US)
    ) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart_i(tb_restart[g]),
      .tick_o   (tb_tick[g])
    );

    cseq_ucount #(
      .W(UW)
    ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear_i(tb_restart[g]),
      .tick_i (tb_tick[g]),
      .next_o (tb_next[g])
    );
  end

  assign seq_us = tb_next[TB_SEQ];
  assign don_us = tb_next[TB_DON];

  assign abort    = (state_q == ST_WAIT) && !cmplt_hit && (seq_us >= TMO_C);
  assign done_due = (state_q == ST_DLY) && (don_us >= DONE_C);

  // ---------------------------------------------------------------
  // Sequence control
  // ---------------------------------------------------------------
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept)                state_d = ST_LEAD;
      ST_LEAD: if (seq_us >= CONV_ON_C)   state_d = ST_WAIT;
      ST_WAIT: begin
        if (cmplt_hit)  state_d = ST_DLY;
        else if (abort) state_d = ST_IDLE;
      end
      ST_DLY: if (done_due) state_d = (seq_us >= END_C) ? ST_IDLE : ST_TAIL;
      ST_TAIL: if (seq_us >= END_C)       state_d = ST_IDLE;
      default:                            state_d = ST_IDLE;
    endcase
  end

  // Outputs are decoded from the next state and next count, then registered.
  always_comb begin
    hold_d = (state_d != ST_IDLE) && (seq_us >= HOLD_ON_C) && (seq_us < HOLD_OFF_C);
    conv_d = (state_d != ST_IDLE) && (seq_us >= CONV_ON_C) && (seq_us < CONV_OFF_C);
    err_d  = abort;
    if (accept) begin
      done_n_d = 1'b1;
    end else if (done_due) begin
      done_n_d = 1'b0;
    end else begin
      done_n_d = done_n_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      hold_q   <= 1'b0;
      conv_q   <= 1'b0;
      done_n_q <= 1'b1;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      hold_q   <= hold_d;
      conv_q   <= conv_d;
      done_n_q <= done_n_d;
      err_q    <= err_d;
    end
  end

  assign hold_o       = hold_q;
  assign conv_start_o = conv_q;
  assign done_n_o     = done_n_q;
  assign tmo_err_o    = err_q;

  // ---------------------------------------------------------------
  // Assertions
  // ---------------------------------------------------------------
  // R3
  conv_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (OVERLAP && $rose(conv_start_o)) |-> hold_o);

  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err_o |-> (!hold_o && !conv_start_o && done_n_o));

  // R10
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err_o |=> !tmo_err_o);

  // R9
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_n_o) |-> $past(accept));

  // R6
  done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_n_o) |-> ($past(state_q) == ST_DLY));

  // R8
  no_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> ((state_q != ST_LEAD) || ($past(state_q) == ST_LEAD)));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (!hold_o && !conv_start_o));

endmodule

// File: tb/tb_samp_conv_seq.sv
module tb_samp_conv_seq;
  localparam int N  = 4;
  localparam int HD = 15;
  localparam int HL = 18;
  localparam int CD = 19;
  localparam int CL = 31;
  localparam int DD = 2;
  localparam int TO = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src = 1'b0;
  logic cmp_n = 1'b1;
  logic hold, cs, done_n, err;

  always #10 clk = ~clk;

  samp_conv_seq #(
    .CLK_PER_US(N), .HOLD_DLY_US(HD), .HOLD_LEN_US(HL), .CONV_DLY_US(CD),
    .CONV_LEN_US(CL), .DONE_DLY_US(DD), .CMPLT_TMO_US(TO)
  ) dut (
    .clk(clk), .rst_n(rst_n), .src_start_i(src), .cmplt_n_i(cmp_n),
    .hold_o(hold), .conv_start_o(cs), .done_n_o(done_n), .tmo_err_o(err)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;

  // Event monitor, sampled on the falling edge.
  int t_hold_r, t_hold_f, t_cs_r, t_cs_f, t_done_f, t_done_r, t_err;
  int n_done_r, n_err;
  logic p_hold = 1'b0, p_cs = 1'b0, p_done = 1'b1, p_err = 1'b0;

  always @(negedge clk) begin
    if (hold && !p_hold) t_hold_r = cyc;
    if (!hold && p_hold) t_hold_f = cyc;
    if (cs && !p_cs) t_cs_r = cyc;
    if (!cs && p_cs) t_cs_f = cyc;
    if (!done_n && p_done) t_done_f = cyc;
    if (done_n && !p_done) begin t_done_r = cyc; n_done_r++; end
    if (err) n_err++;
    if (err && !p_err) t_err = cyc;
    p_hold = hold; p_cs = cs; p_done = done_n; p_err = err;
  end

  function automatic int at(input int base, input int us);
    return base + us * N;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // d: completion delay in clocks after convert-start is seen high.
  task automatic run_seq(input int d, input int glitch_at, input int busy_at);
    int e0, cmp_at, cs_seen, rel;
    bit to, was_low, cmp_low;
    to = (d >= TO * N);
    was_low = !done_n;
    t_hold_r = -1; t_hold_f = -1; t_cs_r = -1; t_cs_f = -1;
    t_done_f = -1; t_done_r = -1; t_err = -1; n_done_r = 0; n_err = 0;
    cmp_at = -1; cs_seen = -1; cmp_low = 1'b0;
    src = 1'b1;
    e0 = cyc + 1;
    do begin
      @(negedge clk);
      rel = cyc - e0;
      src = (rel == busy_at);
      if (cs && cs_seen < 0) cs_seen = cyc;
      if (cs_seen >= 0 && cyc == cs_seen + d && !cmp_low) begin
        cmp_low = 1'b1;
        cmp_at = cyc + 1;
      end
      cmp_n = !((rel == glitch_at) || cmp_low);
    end while (cyc < at(e0, CD + CL) + 1);
    cmp_n = 1'b1;

    if (was_low) chk(n_done_r == 1 && t_done_r == e0, "R9 done release", t_done_r, e0);
    else         chk(n_done_r == 0, "R9 no spurious release", n_done_r, 0);
    chk(t_hold_r == at(e0, HD), "R2 hold rise", t_hold_r, at(e0, HD));
    chk(t_hold_f == at(e0, HD + HL), "R4 hold fall", t_hold_f, at(e0, HD + HL));
    chk(t_cs_r == at(e0, CD), "R3 convert-start rise", t_cs_r, at(e0, CD));
    chk(t_cs_r > t_hold_r && t_cs_r < t_hold_f, "R3 overlap with hold", t_cs_r, t_hold_r);
    if (to) begin
      chk(t_cs_f == at(e0, CD + TO), "R10 convert-start abort", t_cs_f, at(e0, CD + TO));
      chk(n_err == 1 && t_err == at(e0, CD + TO), "R10 error pulse", t_err, at(e0, CD + TO));
      chk(t_done_f == -1, "R10 done stays high", t_done_f, -1);
    end else begin
      chk(t_cs_f == at(e0, CD + CL), "R5 convert-start fall", t_cs_f, at(e0, CD + CL));
      chk(n_err == 0, "R10 no error", n_err, 0);
      chk(t_done_f == cmp_at + DD * N, "R6 done assert", t_done_f, cmp_at + DD * N);
      if (glitch_at >= 0)
        chk(t_done_f == cmp_at + DD * N, "R7 early flag ignored", t_done_f, cmp_at + DD * N);
    end
    if (busy_at >= 0)
      chk(n_done_r == (was_low ? 1 : 0) && t_hold_f == at(e0, HD + HL),
          "R8 busy start ignored", n_done_r, was_low ? 1 : 0);
    chk(!hold && !cs, "R11 idle after sequence", {hold, cs}, 0);
  endtask

  initial begin
    int d, g, b;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    chk(hold == 1'b0, "R1 hold reset", hold, 0);
    chk(cs == 1'b0, "R1 convert-start reset", cs, 0);
    chk(done_n == 1'b1, "R1 done reset", done_n, 1);
    chk(err == 1'b0, "R1 error reset", err, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(hold == 1'b0 && cs == 1'b0 && done_n == 1'b1, "R1 after reset", {hold, cs, done_n}, 1);

    // Directed corners.
    run_seq(12 * N - 1, -1, -1);          // nominal completion
    run_seq(5, 7 * N, -1);                // early completion glitch (R7)
    run_seq(30, -1, 25 * N);              // start edge while busy (R8)
    run_seq(TO * N - 1, CD * N - 2, -1);  // completion on last legal edge
    run_seq(TO * N, -1, -1);              // one clock too late: timeout
    run_seq(0, -1, 3);                    // after timeout, done was high
    run_seq(0, -1, -1);                   // immediate completion

    // Random mix.
    for (int i = 0; i < 40; i++) begin
      d = $urandom_range(0, TO * N + 8);
      g = ($urandom_range(0, 1) == 1) ? $urandom_range(1, CD * N - 2) : -1;
      b = ($urandom_range(0, 1) == 1) ? $urandom_range(1, (CD + TO - 1) * N) : -1;
      run_seq(d, g, b);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule